// File: doc/BRIEF.md
# Circular Execution Trace Buffer

This debug block keeps a rolling history of processor state. On every instruction fetch strobe it stores one entry in a circular history of 1024 slots. Each entry holds the fetch address, the eight address registers, the eight data registers and the 16-bit status word. The oldest entry is overwritten once the history is full.

A fetch from an odd address counts as illegal. That fetch is still written as the newest entry, then the block raises a sticky fault flag and stops capturing. Debug logic then pulses a read strobe once per entry. The entries come out oldest first, and each one appears with a one-cycle valid pulse. A done flag marks the last of the 1024 entries. A clear input releases the freeze and lets capture resume. The history and the write position are kept across the clear.

Top module: `trace_buffer`

## Requirements
- R1: After reset, `faultFlag`, `rdValid` and `rdDone` are low, the write position is slot 0, and every slot counts as unwritten.
- R2: A `fetchStb` that is accepted while capturing writes the entry `{regState, fetchAddr}` at the current write position, then advances the position by one, modulo 1024. In `rdData`, bits [31:0] hold the fetch address. Bits [32+32k +: 32] hold address register k for k = 0..7, then data register k at bits [288+32k +: 32]. The status word sits in bits [559:544].
- R3: An accepted fetch whose address has bit 0 set is written like any other entry and becomes the newest one. `faultFlag` is high in the cycle after that fetch.
- R4: While `faultFlag` is high, `fetchStb` is ignored. The history and the write position do not change.
- R5: While frozen and before done, each `readStb` makes `rdValid` high for exactly the next cycle. `rdData` then holds the next entry, starting at the slot at the write position (the oldest entry) and stepping forward modulo 1024.
- R6: `rdDone` goes high together with the valid pulse of the 1024th entry. After that, `readStb` produces no further valid pulse.
- R7: `readStb` has no effect while `faultFlag` is low.
- R8: `clearFreeze` brings `faultFlag` and `rdDone` low in the next cycle and resumes capture. A fetch in the same cycle as `clearFreeze` is ignored. History and write position are kept. The next readout starts again from the oldest entry.
- R9: A slot that has not been written since reset reads out as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchStb | input | 1 | One instruction fetch this cycle |
| fetchAddr | input | 32 | Address of the fetch |
| regState | input | 528 | A0..A7, D0..D7 (32 bits each) and a 16-bit status word at the top |
| clearFreeze | input | 1 | Release the freeze and resume capture |
| readStb | input | 1 | Request the next history entry |
| faultFlag | output | 1 | Odd-address fetch seen, capture frozen |
| rdValid | output | 1 | `rdData` holds an entry this cycle |
| rdData | output | 560 | History entry |
| rdDone | output | 1 | All 1024 entries have been read out |

## Verification
The hardest state to reach is a readout that begins mid-array after the pointer has wrapped. In that state the oldest entry is not in slot 0, and stale and fresh data sit side by side.

The bench gets there in stages. It drives 1100 fetches with distinct, sequence-coded register values, so the pointer wraps and sits at a non-zero slot. It then freezes with an odd fetch, reads part of the history and clears. A second odd fetch follows, and the full readout must restart at the new oldest slot, with all 1024 entries checked in order.

An earlier short trace covers the other side: unwritten zero slots followed by a handful of real entries.

// File: rtl/trace_pkg.sv
package trace_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // write one entry and advance pointer
    logic readEntry;  // present next history entry
    logic restart;    // rewind readout offset
  } ctrlStb_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fetchStb,
  input  logic     fetchOdd,
  input  logic     clearFreeze,
  input  logic     readStb,
  input  logic     lastEntry,
  output ctrlStb_t stb,
  output logic     faultFlag,
  output logic     rdDone
);
  logic faultQ;
  logic doneQ;

  always_comb begin
    stb.restart   = clearFreeze;
    stb.capture   = fetchStb && !faultQ && !clearFreeze;
    stb.readEntry = readStb && faultQ && !doneQ && !clearFreeze;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= 1'b0;
      doneQ  <= 1'b0;
    end else if (clearFreeze) begin
      faultQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (stb.capture && fetchOdd) faultQ <= 1'b1;
      if (stb.readEntry && lastEntry) doneQ <= 1'b1;
    end
  end

  assign faultFlag = faultQ;
  assign rdDone    = doneQ;
endmodule

// File: rtl/trace_data.sv
module trace_data
  import trace_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 560
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [ENTRY_W-1:0] wrEntry,
  output logic               lastEntry,
  output logic               rdValid,
  output logic [ENTRY_W-1:0] rdData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENTRY_W-1:0] histMem [DEPTH];
  logic [DEPTH-1:0]   slotUsed;
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdOfs;
  logic [PTR_W-1:0]   rdIdx;

  assign rdIdx     = wrPtr + rdOfs;
  assign lastEntry = (rdOfs == PTR_W'(DEPTH - 1));

  // storage array, no reset; validity tracked separately
  always_ff @(posedge clk) begin
    if (stb.capture) histMem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotUsed <= '0;
      wrPtr    <= '0;
      rdOfs    <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdValid <= stb.readEntry;
      if (stb.capture) begin
        slotUsed[wrPtr] <= 1'b1;
        wrPtr           <= wrPtr + 1'b1;
      end
      if (stb.restart) begin
        rdOfs <= '0;
      end else if (stb.readEntry) begin
        rdData <= slotUsed[rdIdx] ? histMem[rdIdx] : '0;
        rdOfs  <= rdOfs + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_buffer.sv
module trace_buffer
  import trace_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 32,
  parameter int N_BANK = 8,
  parameter int SR_W   = 16,
  localparam int REGS_W  = 2 * N_BANK * REG_W + SR_W,
  localparam int ENTRY_W = REGS_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchStb,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic [REGS_W-1:0]  regState,
  input  logic               clearFreeze,
  input  logic               readStb,
  output logic               faultFlag,
  output logic               rdValid,
  output logic [ENTRY_W-1:0] rdData,
  output logic               rdDone
);
  ctrlStb_t stb;
  logic     lastEntry;

  trace_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchStb   (fetchStb),
    .fetchOdd   (fetchAddr[0]),
    .clearFreeze(clearFreeze),
    .readStb    (readStb),
    .lastEntry  (lastEntry),
    .stb        (stb),
    .faultFlag  (faultFlag),
    .rdDone     (rdDone)
  );

  trace_data #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrEntry  ({regState, fetchAddr}),
    .lastEntry(lastEntry),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );
endmodule

// File: rtl/trace_buffer_chk.sv
module trace_buffer_chk (
  input logic clk,
  input logic rstN,
  input logic fetchStb,
  input logic fetchOdd,
  input logic clearFreeze,
  input logic readStb,
  input logic faultFlag,
  input logic rdValid,
  input logic rdDone
);
  p_odd_freezes_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchStb && fetchOdd && !faultFlag && !clearFreeze |=> faultFlag);

  p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag && !clearFreeze |=> faultFlag);

  p_valid_only_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> faultFlag);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && !clearFreeze |=> rdDone);

  p_no_read_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && !clearFreeze |=> !rdValid);

  p_clear_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearFreeze |=> !faultFlag && !rdDone && !rdValid);

  p_read_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    readStb && faultFlag && !rdDone && !clearFreeze |=> rdValid);
endmodule

bind trace_buffer trace_buffer_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fetchStb   (fetchStb),
  .fetchOdd   (fetchAddr[0]),
  .clearFreeze(clearFreeze),
  .readStb    (readStb),
  .faultFlag  (faultFlag),
  .rdValid    (rdValid),
  .rdDone     (rdDone)
);

// File: tb/test_trace_buffer.sv
module test_trace_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 1024;
  localparam int ADDR_W  = 32;
  localparam int REG_W   = 32;
  localparam int REGS_W  = 16 * REG_W + 16;
  localparam int ENTRY_W = REGS_W + ADDR_W;

  logic clk = 1'b0;
  logic rstN;
  logic fetchStb;
  logic [ADDR_W-1:0] fetchAddr;
  logic [REGS_W-1:0] regState;
  logic clearFreeze;
  logic readStb;
  logic faultFlag;
  logic rdValid;
  logic [ENTRY_W-1:0] rdData;
  logic rdDone;

  int nChecks = 0;
  int nFails  = 0;
  int seqNo   = 0;

  logic [ENTRY_W-1:0] modelMem [DEPTH];
  int modelPtr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_buffer i_trace_buffer (
    .clk(clk), .rstN(rstN), .fetchStb(fetchStb), .fetchAddr(fetchAddr),
    .regState(regState), .clearFreeze(clearFreeze), .readStb(readStb),
    .faultFlag(faultFlag), .rdValid(rdValid), .rdData(rdData), .rdDone(rdDone)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [ENTRY_W-1:0] act,
                       input logic [ENTRY_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [REGS_W-1:0] makeRegs(input int s);
    logic [REGS_W-1:0] r;
    for (int k = 0; k < 16; k++)
      r[k*REG_W +: REG_W] = (s * 32'h0001_0003) ^ (32'(k) << 24);
    r[REGS_W-1 -: 16] = 16'(s) ^ 16'hA5A5;
    return r;
  endfunction

  // one fetch; updates the model only when capture should accept it
  task automatic doFetch(input logic odd);
    logic [ADDR_W-1:0] a;
    logic              accept;
    a = (32'(seqNo) << 2) | 32'(odd);
    accept = !faultFlag;
    fetchStb  = 1'b1;
    fetchAddr = a;
    regState  = makeRegs(seqNo);
    if (accept) begin
      modelMem[modelPtr] = {regState, a};
      modelPtr = (modelPtr + 1) % DEPTH;
    end
    seqNo++;
    tick();
    fetchStb = 1'b0;
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      readStb = 1'b1;
      tick();
      check({tag, " R5 valid"}, ENTRY_W'(rdValid), 1);
      check({tag, " R5 data"}, rdData, modelMem[(modelPtr + i) % DEPTH]);
      check({tag, " R6 done"}, ENTRY_W'(rdDone), ENTRY_W'(i == DEPTH - 1));
    end
    readStb = 1'b1;
    tick();
    check({tag, " R6 no valid after done"}, ENTRY_W'(rdValid), 0);
    readStb = 1'b0;
    tick();
  endtask

  task automatic testReset();
    check("R1 fault", ENTRY_W'(faultFlag), 0);
    check("R1 valid", ENTRY_W'(rdValid), 0);
    check("R1 done", ENTRY_W'(rdDone), 0);
  endtask

  task automatic testReadWhileCapturing();
    readStb = 1'b1;
    tick();
    check("R7 read ignored", ENTRY_W'(rdValid), 0);
    readStb = 1'b0;
    tick();
    check("R7 still no valid", ENTRY_W'(rdValid), 0);
  endtask

  task automatic testShortTrace();
    for (int i = 0; i < 5; i++) doFetch(1'b0);
    check("R2 no fault on even", ENTRY_W'(faultFlag), 0);
    doFetch(1'b1);
    check("R3 fault after odd", ENTRY_W'(faultFlag), 1);
    doFetch(1'b0);   // ignored while frozen (R4)
    doFetch(1'b1);
    check("R4 fault holds", ENTRY_W'(faultFlag), 1);
    // R9: slots 6..1023 unwritten read as zero, then entries 0..5
    readAll("short R9");
  endtask

  task automatic testWrapAndClear();
    clearFreeze = 1'b1;
    fetchStb = 1'b1;   // fetch during clear is ignored (R8)
    fetchAddr = 32'h0000_0001;
    regState = makeRegs(9999);
    tick();
    clearFreeze = 1'b0;
    fetchStb = 1'b0;
    check("R8 fault cleared", ENTRY_W'(faultFlag), 0);
    check("R8 done cleared", ENTRY_W'(rdDone), 0);
    for (int i = 0; i < 1099; i++) doFetch(1'b0);
    check("R2 no fault while wrapping", ENTRY_W'(faultFlag), 0);
    doFetch(1'b1);
    check("R3 fault after wrap", ENTRY_W'(faultFlag), 1);
    // partial readout then clear
    for (int i = 0; i < 10; i++) begin
      readStb = 1'b1;
      tick();
      check("R5 partial data", rdData, modelMem[(modelPtr + i) % DEPTH]);
    end
    readStb = 1'b0;
    clearFreeze = 1'b1;
    tick();
    clearFreeze = 1'b0;
    check("R8 clear after partial", ENTRY_W'(faultFlag), 0);
    for (int i = 0; i < 3; i++) doFetch(1'b0);
    doFetch(1'b1);
    check("R3 refreeze", ENTRY_W'(faultFlag), 1);
    readAll("wrap R2 R8");
  endtask

  initial begin
    rstN = 1'b0; fetchStb = 1'b0; fetchAddr = '0; regState = '0;
    clearFreeze = 1'b0; readStb = 1'b0;
    for (int i = 0; i < DEPTH; i++) modelMem[i] = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testReadWhileCapturing();
    testShortTrace();
    testWrapAndClear();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule